// File: doc/BRIEF.md
# Serial EEPROM SPI Command Front End

This block is the slave-side serial front end of a small SPI EEPROM. It runs on a fast system clock that oversamples the pins. The chip-select, serial-clock, data-in and pause inputs pass through synchronisers, and the block finds serial-clock edges from the synchronised copies. It works in SPI mode 0 and mode 3. It decodes one 8-bit command per select period and collects a 16-bit address for memory commands. It streams read bytes out MSB first and turns write traffic into single-cycle request pulses for the sibling blocks: the write-enable latch, the status logic, the array read port and the page buffer.

The serial output has its own enable so the pad can float it. The block itself holds no status bits, applies no protection rules and does no program timing. It receives the live status byte and a busy flag, and it hands out requests. Memory read data must be valid on `mem_rd_data_i` in the second cycle after `mem_rd_req_o` is high.

The control state machine has these states. `ST_IDLE` is entered whenever select is inactive. `ST_OPCODE` follows select going active. The decode of the command byte leads to one of the following:
- `ST_ADDR_HI` then `ST_ADDR_LO`, for the two memory commands.
- `ST_WEN_PEND`, for the enable-set and enable-clear commands.
- `ST_RD_STAT`, for a status read.
- `ST_WR_STAT` then `ST_STAT_PEND` after its byte, for a status write.
- `ST_IGNORE`, for an unknown command, or for any command other than status read while busy.

`ST_ADDR_LO` moves to `ST_RD_DATA` or `ST_WR_DATA`. Any further rising edge in `ST_WEN_PEND` or `ST_STAT_PEND` moves to `ST_IGNORE`. Select going inactive returns every state to `ST_IDLE`, and the actions that wait for the end of the transfer fire on that exit.

Top module: `spi_eeprom_front`

## Requirements
- R1: SI is sampled on SCK rising edges and SO changes only on SCK falling edges, with SCK idling low (mode 0) or high (mode 3) at select.
- R2: Command codes: 0x06 pulses `wen_set_o` and 0x04 pulses `wen_clr_o` at the end of the transfer; 0x05 reads status; 0x01 writes status; 0x03 reads memory; 0x02 writes memory. At most one end-of-transfer strobe is high in any cycle.
- R3: Any other command byte produces no request, and `so_oe_o` stays low until select goes inactive.
- R4: Memory commands take a 16-bit address, MSB first; only its low ADDR_W bits are used and the rest are ignored.
- R5: A memory read drives the addressed byte from the SCK falling edge after the last address bit, then the next address for each following byte, wrapping from the top address to 0.
- R6: A status read returns `stat_i` repeatedly; each byte is captured when the previous byte's last bit is clocked in, so a change of `stat_i` shows in the next byte.
- R7: In a memory write each complete data byte pulses `pg_load_o` with its address. The address then advances in its low PAGE_W bits only, wrapping inside the page. `wr_commit_o` pulses when select goes inactive after at least one complete data byte.
- R8: A status write pulses `stat_wr_o` with the received byte when select goes inactive directly after that byte.
- R9: 0x06 and 0x04 act only if select goes inactive directly after the 8th command bit; any further bit cancels them.
- R10: While `busy_i` is high at command decode, only 0x05 is accepted; every other command is ignored as in R3.
- R11: After reset, and whenever select is inactive, `so_oe_o` is low.
- R12: HOLD low, changed while SCK is low, pauses the transfer: `so_oe_o` goes low, SCK and SI are ignored, and the bit position is kept until HOLD returns high.
- R13: Select going inactive mid-byte discards the partial byte and restarts bit counting at the next select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Active-low reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| si_i | input | 1 | Serial data in |
| hold_n_i | input | 1 | Pause input, active low |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o |
| busy_i | input | 1 | Internal write cycle in progress |
| stat_i | input | 8 | Live status byte |
| wen_set_o | output | 1 | Write-enable set strobe |
| wen_clr_o | output | 1 | Write-enable clear strobe |
| stat_wr_o | output | 1 | Status write strobe |
| stat_wr_data_o | output | 8 | Status byte to write |
| mem_rd_req_o | output | 1 | Array read request |
| mem_rd_addr_o | output | ADDR_W | Array read address |
| mem_rd_data_i | input | 8 | Array read data, valid two cycles after the request |
| pg_load_o | output | 1 | Page buffer byte load |
| pg_addr_o | output | ADDR_W | Address of the loaded byte |
| pg_data_o | output | 8 | Loaded byte |
| wr_commit_o | output | 1 | Start programming of the loaded page |

## Verification
The bench builds the block with ADDR_W = 6 and PAGE_W = 3, giving a 64-byte array and 8-byte pages. With these values a read that crosses the top address back to 0 and a page write that rolls over inside its page each take only a few bytes. The bench runs SCK at eight system clocks per half period, which leaves room for synchroniser and read-data latency. It runs in both SCK idle polarities.

// File: rtl/eep_front_pkg.sv
`timescale 1ns/1ps
package eep_front_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_RD_DATA,
        ST_RD_STAT,
        ST_WR_STAT,
        ST_STAT_PEND,
        ST_WR_DATA,
        ST_WEN_PEND,
        ST_IGNORE
    } eep_state_t;

    localparam logic [7:0] OP_WEN_SET = 8'h06;
    localparam logic [7:0] OP_WEN_CLR = 8'h04;
    localparam logic [7:0] OP_STAT_RD = 8'h05;
    localparam logic [7:0] OP_STAT_WR = 8'h01;
    localparam logic [7:0] OP_MEM_RD  = 8'h03;
    localparam logic [7:0] OP_MEM_WR  = 8'h02;

    // State that follows a completed command byte.
    function automatic eep_state_t decode_op(input logic [7:0] op, input logic busy);
        eep_state_t s;
        s = ST_IGNORE;
        if (op == OP_STAT_RD)
            s = ST_RD_STAT;
        else if (!busy) begin
            case (op)
                OP_WEN_SET, OP_WEN_CLR: s = ST_WEN_PEND;
                OP_STAT_WR:             s = ST_WR_STAT;
                OP_MEM_RD, OP_MEM_WR:   s = ST_ADDR_HI;
                default:                s = ST_IGNORE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/spi_in_sync.sv
`timescale 1ns/1ps
module spi_in_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pipe <= {STAGES{RST_VAL[b]}};
            else
                pipe <= {pipe[STAGES-2:0], d_i[b]};
        end
        assign q_o[b] = pipe[STAGES-1];
    end
endmodule

// File: rtl/spi_bit_engine.sv
`timescale 1ns/1ps
module spi_bit_engine (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_s,
    input  logic       sck_s,
    input  logic       si_s,
    input  logic       hold_s,
    output logic       sel_o,
    output logic       paused_o,
    output logic       rise_o,
    output logic       fall_o,
    output logic       byte_done_o,
    output logic [7:0] rx_byte_o,
    output logic       cs_rise_o
);
    logic       sck_q;
    logic       cs_q;
    logic       paused_q;
    logic [2:0] bit_cnt;
    logic [6:0] rx_q;

    assign sel_o       = !cs_s;
    assign paused_o    = paused_q;
    assign rise_o      = sel_o && !paused_q && sck_s && !sck_q;
    assign fall_o      = sel_o && !paused_q && !sck_s && sck_q;
    assign byte_done_o = rise_o && (bit_cnt == 3'd7);
    assign rx_byte_o   = {rx_q, si_s};
    assign cs_rise_o   = cs_s && !cs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q    <= 1'b0;
            cs_q     <= 1'b1;
            paused_q <= 1'b0;
            bit_cnt  <= '0;
            rx_q     <= '0;
        end else begin
            sck_q <= sck_s;
            cs_q  <= cs_s;
            if (cs_s) begin
                paused_q <= 1'b0;
                bit_cnt  <= '0;
            end else begin
                if (!sck_s)
                    paused_q <= !hold_s;
                if (rise_o) begin
                    rx_q    <= rx_byte_o[6:0];
                    bit_cnt <= bit_cnt + 3'd1;
                end
            end
        end
    end
endmodule

// File: rtl/eep_cmd_fsm.sv
`timescale 1ns/1ps
module eep_cmd_fsm
    import eep_front_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              rise,
    input  logic              byte_done,
    input  logic [7:0]        rx_byte,
    input  logic              cs_rise,
    input  logic              busy_i,
    input  logic [7:0]        stat_i,
    input  logic [7:0]        mem_rd_data_i,
    output eep_state_t        state_o,
    output logic              wen_set_o,
    output logic              wen_clr_o,
    output logic              stat_wr_o,
    output logic [7:0]        stat_wr_data_o,
    output logic              mem_rd_req_o,
    output logic [ADDR_W-1:0] mem_rd_addr_o,
    output logic              pg_load_o,
    output logic [ADDR_W-1:0] pg_addr_o,
    output logic [7:0]        pg_data_o,
    output logic              wr_commit_o,
    output logic              tx_load_o,
    output logic [7:0]        tx_byte_o,
    output logic              rd_phase_o
);
    localparam logic [ADDR_W-1:0] PAGE_MASK = {{(ADDR_W-PAGE_W){1'b0}}, {PAGE_W{1'b1}}};

    eep_state_t        state_q, state_d;
    logic [7:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] full_addr;
    logic [ADDR_W-1:0] page_next;
    logic              wr_any_q;
    logic              rd_pend_q;
    logic              rd_wait_q;

    if (ADDR_W > 8) begin : g_wide
        logic [ADDR_W-9:0] hi_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                hi_q <= '0;
            else if (state_q == ST_ADDR_HI && byte_done)
                hi_q <= rx_byte[ADDR_W-9:0];
        end
        assign full_addr = {hi_q, rx_byte};
    end else begin : g_narrow
        assign full_addr = rx_byte[ADDR_W-1:0];
    end

    assign page_next  = (addr_q & ~PAGE_MASK) | ((addr_q + 1'b1) & PAGE_MASK);
    assign state_o    = state_q;
    assign rd_phase_o = (state_q == ST_RD_DATA) || (state_q == ST_RD_STAT);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!sel) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_OPCODE;
                ST_OPCODE:   if (byte_done) state_d = decode_op(rx_byte, busy_i);
                ST_ADDR_HI:  if (byte_done) state_d = ST_ADDR_LO;
                ST_ADDR_LO:  if (byte_done) state_d = (op_q == OP_MEM_RD) ? ST_RD_DATA : ST_WR_DATA;
                ST_WR_STAT:  if (byte_done) state_d = ST_STAT_PEND;
                ST_WEN_PEND, ST_STAT_PEND: if (rise) state_d = ST_IGNORE;
                ST_RD_DATA, ST_RD_STAT, ST_WR_DATA, ST_IGNORE: state_d = state_q;
                default:     state_d = ST_IGNORE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q           <= '0;
            addr_q         <= '0;
            wr_any_q       <= 1'b0;
            rd_pend_q      <= 1'b0;
            rd_wait_q      <= 1'b0;
            wen_set_o      <= 1'b0;
            wen_clr_o      <= 1'b0;
            stat_wr_o      <= 1'b0;
            stat_wr_data_o <= '0;
            mem_rd_req_o   <= 1'b0;
            mem_rd_addr_o  <= '0;
            pg_load_o      <= 1'b0;
            pg_addr_o      <= '0;
            pg_data_o      <= '0;
            wr_commit_o    <= 1'b0;
            tx_load_o      <= 1'b0;
            tx_byte_o      <= '0;
        end else begin
            wen_set_o    <= 1'b0;
            wen_clr_o    <= 1'b0;
            stat_wr_o    <= 1'b0;
            mem_rd_req_o <= 1'b0;
            pg_load_o    <= 1'b0;
            wr_commit_o  <= 1'b0;
            tx_load_o    <= 1'b0;
            rd_pend_q    <= 1'b0;
            rd_wait_q    <= rd_pend_q;
            if (rd_wait_q) begin
                tx_load_o <= 1'b1;
                tx_byte_o <= mem_rd_data_i;
            end
            if (cs_rise) begin
                unique case (state_q)
                    ST_WEN_PEND: begin
                        wen_set_o <= (op_q == OP_WEN_SET);
                        wen_clr_o <= (op_q == OP_WEN_CLR);
                    end
                    ST_STAT_PEND: stat_wr_o   <= 1'b1;
                    ST_WR_DATA:   wr_commit_o <= wr_any_q;
                    default: ;
                endcase
            end
            if (byte_done) begin
                unique case (state_q)
                    ST_OPCODE: begin
                        op_q     <= rx_byte;
                        wr_any_q <= 1'b0;
                        if (decode_op(rx_byte, busy_i) == ST_RD_STAT) begin
                            tx_load_o <= 1'b1;
                            tx_byte_o <= stat_i;
                        end
                    end
                    ST_ADDR_LO: begin
                        if (op_q == OP_MEM_RD) begin
                            mem_rd_req_o  <= 1'b1;
                            mem_rd_addr_o <= full_addr;
                            addr_q        <= full_addr + 1'b1;
                            rd_pend_q     <= 1'b1;
                        end else begin
                            addr_q <= full_addr;
                        end
                    end
                    ST_RD_DATA: begin
                        mem_rd_req_o  <= 1'b1;
                        mem_rd_addr_o <= addr_q;
                        addr_q        <= addr_q + 1'b1;
                        rd_pend_q     <= 1'b1;
                    end
                    ST_RD_STAT: begin
                        tx_load_o <= 1'b1;
                        tx_byte_o <= stat_i;
                    end
                    ST_WR_DATA: begin
                        pg_load_o <= 1'b1;
                        pg_addr_o <= addr_q;
                        pg_data_o <= rx_byte;
                        addr_q    <= page_next;
                        wr_any_q  <= 1'b1;
                    end
                    ST_WR_STAT: stat_wr_data_o <= rx_byte;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_tx_shift.sv
`timescale 1ns/1ps
module spi_tx_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       paused,
    input  logic       fall,
    input  logic       rd_phase,
    input  logic       load,
    input  logic [7:0] load_byte,
    output logic       so_o,
    output logic       so_oe_o
);
    logic [7:0] sh_q;
    logic       started_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q      <= '0;
            started_q <= 1'b0;
            so_o      <= 1'b0;
            so_oe_o   <= 1'b0;
        end else begin
            if (!rd_phase)
                started_q <= 1'b0;
            else if (fall)
                started_q <= 1'b1;
            if (load) begin
                sh_q <= load_byte;
            end else if (fall && rd_phase) begin
                so_o <= sh_q[7];
                sh_q <= {sh_q[6:0], 1'b0};
            end
            so_oe_o <= rd_phase && sel && !paused && (started_q || fall);
        end
    end
endmodule

// File: rtl/spi_eeprom_front.sv
`timescale 1ns/1ps
module spi_eeprom_front
    import eep_front_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sck_i,
    input  logic              si_i,
    input  logic              hold_n_i,
    output logic              so_o,
    output logic              so_oe_o,
    input  logic              busy_i,
    input  logic [7:0]        stat_i,
    output logic              wen_set_o,
    output logic              wen_clr_o,
    output logic              stat_wr_o,
    output logic [7:0]        stat_wr_data_o,
    output logic              mem_rd_req_o,
    output logic [ADDR_W-1:0] mem_rd_addr_o,
    input  logic [7:0]        mem_rd_data_i,
    output logic              pg_load_o,
    output logic [ADDR_W-1:0] pg_addr_o,
    output logic [7:0]        pg_data_o,
    output logic              wr_commit_o
);
    logic [3:0] pins_s;
    logic       sel_w, paused_w, rise_w, fall_w, byte_done_w, cs_rise_w;
    logic [7:0] rx_byte_w;
    logic       tx_load_w, rd_phase_w;
    logic [7:0] tx_byte_w;
    eep_state_t state_w;

    spi_in_sync #(.WIDTH(4), .STAGES(2), .RST_VAL(4'b1001)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({cs_n_i, sck_i, si_i, hold_n_i}),
        .q_o(pins_s)
    );

    spi_bit_engine u_eng (
        .clk(clk), .rst_n(rst_n),
        .cs_s(pins_s[3]), .sck_s(pins_s[2]), .si_s(pins_s[1]), .hold_s(pins_s[0]),
        .sel_o(sel_w), .paused_o(paused_w), .rise_o(rise_w), .fall_o(fall_w),
        .byte_done_o(byte_done_w), .rx_byte_o(rx_byte_w), .cs_rise_o(cs_rise_w)
    );

    eep_cmd_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sel(sel_w), .rise(rise_w), .byte_done(byte_done_w), .rx_byte(rx_byte_w),
        .cs_rise(cs_rise_w), .busy_i(busy_i), .stat_i(stat_i), .mem_rd_data_i(mem_rd_data_i),
        .state_o(state_w),
        .wen_set_o(wen_set_o), .wen_clr_o(wen_clr_o),
        .stat_wr_o(stat_wr_o), .stat_wr_data_o(stat_wr_data_o),
        .mem_rd_req_o(mem_rd_req_o), .mem_rd_addr_o(mem_rd_addr_o),
        .pg_load_o(pg_load_o), .pg_addr_o(pg_addr_o), .pg_data_o(pg_data_o),
        .wr_commit_o(wr_commit_o),
        .tx_load_o(tx_load_w), .tx_byte_o(tx_byte_w), .rd_phase_o(rd_phase_w)
    );

    spi_tx_shift u_tx (
        .clk(clk), .rst_n(rst_n),
        .sel(sel_w), .paused(paused_w), .fall(fall_w), .rd_phase(rd_phase_w),
        .load(tx_load_w), .load_byte(tx_byte_w),
        .so_o(so_o), .so_oe_o(so_oe_o)
    );
endmodule

// File: rtl/spi_eeprom_front_chk.sv
`timescale 1ns/1ps
module spi_eeprom_front_chk
    import eep_front_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sel,
    input logic       paused,
    input eep_state_t state,
    input logic       so_oe,
    input logic       busy,
    input logic       wen_set,
    input logic       wen_clr,
    input logic       stat_wr,
    input logic       wr_commit
);
    p_oe_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !so_oe);

    p_hold_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        paused |=> !so_oe);

    p_bad_op_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |=> !so_oe);

    p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wen_set, wen_clr, stat_wr, wr_commit}));

    p_busy_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_OPCODE &&
         (state == ST_ADDR_HI || state == ST_WR_STAT || state == ST_WEN_PEND))
        |-> !$past(busy));

    p_wen_needs_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wen_set || wen_clr) |-> ($past(state) == ST_WEN_PEND));

    p_commit_from_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> ($past(state) == ST_WR_DATA));

    p_stat_wr_from_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |-> ($past(state) == ST_STAT_PEND));
endmodule

bind spi_eeprom_front spi_eeprom_front_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sel(sel_w), .paused(paused_w), .state(state_w),
    .so_oe(so_oe_o), .busy(busy_i), .wen_set(wen_set_o), .wen_clr(wen_clr_o),
    .stat_wr(stat_wr_o), .wr_commit(wr_commit_o)
);

// File: tb/spi_eeprom_front_tb_top.sv
`timescale 1ns/1ps
module spi_eeprom_front_tb_top;
    localparam int ADDR_W = 6;
    localparam int PAGE_W = 3;
    localparam int HALF   = 8;
    localparam int EV_WSET = 0, EV_WCLR = 1, EV_SWR = 2, EV_RREQ = 3, EV_PLD = 4, EV_CMT = 5;

    typedef struct {
        int    kind;
        int    addr;
        int    data;
        string req;
    } ev_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic busy = 1'b0;
    logic [7:0] stat_v = 8'h00;
    logic [7:0] mem_q = 8'h00;
    logic so, so_oe, wen_set, wen_clr, stat_wr, mem_rd_req, pg_load, wr_commit;
    logic [7:0] stat_wr_data, pg_data;
    logic [ADDR_W-1:0] mem_rd_addr, pg_addr;

    int checks = 0, failures = 0;
    bit mode3 = 1'b0;
    bit oe_seen = 1'b0;
    bit done = 1'b0;
    string cur_req = "R11";
    ev_t exp_q[$];

    always #2.5 clk = ~clk;

    spi_eeprom_front #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .si_i(si), .hold_n_i(hold_n),
        .so_o(so), .so_oe_o(so_oe), .busy_i(busy), .stat_i(stat_v),
        .wen_set_o(wen_set), .wen_clr_o(wen_clr), .stat_wr_o(stat_wr),
        .stat_wr_data_o(stat_wr_data), .mem_rd_req_o(mem_rd_req), .mem_rd_addr_o(mem_rd_addr),
        .mem_rd_data_i(mem_q), .pg_load_o(pg_load), .pg_addr_o(pg_addr), .pg_data_o(pg_data),
        .wr_commit_o(wr_commit)
    );

    function automatic logic [7:0] mem_val(input int a);
        return 8'((a * 37 + 5) & 8'hFF);
    endfunction

    // Array model: data is ready for the design to sample two cycles after the request
    always @(posedge clk) if (mem_rd_req) mem_q <= mem_val(int'(mem_rd_addr));

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input int kind, input int addr, input int data, input string req);
        ev_t e;
        e.kind = kind; e.addr = addr; e.data = data; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic observe(input int kind, input int addr, input int data);
        ev_t e;
        if (exp_q.size() == 0) begin
            chk(1'b0, cur_req, "unexpected event kind", kind, -1);
        end else begin
            e = exp_q.pop_front();
            chk(e.kind == kind, e.req, "event kind", kind, e.kind);
            chk(e.addr == addr && e.data == data, e.req, "event addr/data",
                (addr << 8) | data, (e.addr << 8) | e.data);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (so_oe) oe_seen = 1'b1;
            if (wen_set)    observe(EV_WSET, 0, 0);
            if (wen_clr)    observe(EV_WCLR, 0, 0);
            if (stat_wr)    observe(EV_SWR, 0, int'(stat_wr_data));
            if (mem_rd_req) observe(EV_RREQ, int'(mem_rd_addr), 0);
            if (pg_load)    observe(EV_PLD, int'(pg_addr), int'(pg_data));
            if (wr_commit)  observe(EV_CMT, 0, 0);
        end
    end

    task automatic wait_h();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bit_x(input logic b, output logic r);
        if (mode3) sck = 1'b0;
        si = b;
        wait_h();
        r = so;
        sck = 1'b1;
        wait_h();
        if (!mode3) sck = 1'b0;
    endtask

    task automatic byte_x(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) bit_x(b[i], r[i]);
    endtask

    task automatic cs_begin(input bit m3, input string req);
        mode3   = m3;
        cur_req = req;
        sck     = m3;
        wait_h();
        cs_n = 1'b0;
        wait_h();
    endtask

    task automatic cs_end(input string req);
        wait_h();
        cs_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, req, "expected events still pending", exp_q.size(), 0);
        chk(!so_oe, "R11", "so_oe with select inactive", int'(so_oe), 0);
        sck = 1'b0;
        wait_h();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 150000, 0);
            finish_run();
        end
    end

    initial begin : main
        logic [7:0] r;
        logic       rb;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R11: reset state
        chk(!so_oe, "R11", "so_oe after reset", int'(so_oe), 0);
        chk(!wen_set && !pg_load && !mem_rd_req, "R11", "strobes after reset", 0, 0);

        // R2 R1: enable set in mode 0
        cs_begin(1'b0, "R2");
        push(EV_WSET, 0, 0, "R2");
        byte_x(8'h06, r);
        cs_end("R2");

        // R2 R1: enable clear in mode 3
        cs_begin(1'b1, "R1");
        push(EV_WCLR, 0, 0, "R1");
        byte_x(8'h04, r);
        cs_end("R1");

        // R9: an extra bit after the enable command cancels it
        cs_begin(1'b0, "R9");
        byte_x(8'h06, r);
        bit_x(1'b0, rb);
        cs_end("R9");

        // R6: status read repeats and follows the live value
        stat_v = 8'h5C;
        cs_begin(1'b0, "R6");
        byte_x(8'h05, r);
        stat_v = 8'hA3;
        byte_x(8'h00, r);
        chk(r == 8'h5C, "R6", "status byte 1", r, 8'h5C);
        byte_x(8'h00, r);
        chk(r == 8'hA3, "R6", "status byte 2", r, 8'hA3);
        cs_end("R6");

        // R8: status write
        cs_begin(1'b1, "R8");
        push(EV_SWR, 0, 8'h8C, "R8");
        byte_x(8'h01, r);
        byte_x(8'h8C, r);
        cs_end("R8");

        // R5 R4 R1: mode 3 read from 0x123E (low bits 62) wraps past the top
        cs_begin(1'b1, "R5");
        push(EV_RREQ, 62, 0, "R4");
        push(EV_RREQ, 63, 0, "R5");
        push(EV_RREQ, 0, 0, "R5");
        push(EV_RREQ, 1, 0, "R5");
        push(EV_RREQ, 2, 0, "R5");
        byte_x(8'h03, r);
        byte_x(8'h12, r);
        byte_x(8'h3E, r);
        for (int k = 0; k < 4; k++) begin
            byte_x(8'h00, r);
            chk(r == mem_val((62 + k) % 64), "R5", "read byte", r, mem_val((62 + k) % 64));
        end
        cs_end("R5");

        // R7 R4: page write from 0xAB06 rolls over inside an 8-byte page
        cs_begin(1'b0, "R7");
        push(EV_PLD, 6, 8'h11, "R7");
        push(EV_PLD, 7, 8'h22, "R7");
        push(EV_PLD, 0, 8'h33, "R7");
        push(EV_CMT, 0, 0, "R7");
        byte_x(8'h02, r);
        byte_x(8'hAB, r);
        byte_x(8'h06, r);
        byte_x(8'h11, r);
        byte_x(8'h22, r);
        byte_x(8'h33, r);
        cs_end("R7");

        // R3: invalid command keeps output disabled and requests nothing
        cs_begin(1'b0, "R3");
        oe_seen = 1'b0;
        byte_x(8'hAB, r);
        byte_x(8'h06, r);
        byte_x(8'h02, r);
        chk(!oe_seen, "R3", "so_oe after invalid command", int'(oe_seen), 0);
        cs_end("R3");

        // R10: busy blocks everything except status read
        busy   = 1'b1;
        stat_v = 8'h01;
        cs_begin(1'b0, "R10");
        byte_x(8'h06, r);
        cs_end("R10");
        cs_begin(1'b0, "R10");
        oe_seen = 1'b0;
        byte_x(8'h03, r);
        byte_x(8'h00, r);
        byte_x(8'h04, r);
        byte_x(8'h00, r);
        chk(!oe_seen, "R10", "so_oe for read while busy", int'(oe_seen), 0);
        cs_end("R10");
        cs_begin(1'b1, "R10");
        byte_x(8'h05, r);
        byte_x(8'h00, r);
        chk(r == 8'h01, "R10", "status read while busy", r, 8'h01);
        cs_end("R10");
        busy = 1'b0;

        // R12: pause in the middle of a read byte
        cs_begin(1'b0, "R12");
        push(EV_RREQ, 16, 0, "R12");
        push(EV_RREQ, 17, 0, "R12");
        push(EV_RREQ, 18, 0, "R12");
        byte_x(8'h03, r);
        byte_x(8'h00, r);
        byte_x(8'h10, r);
        byte_x(8'h00, r);
        chk(r == mem_val(16), "R12", "read byte before pause", r, mem_val(16));
        for (int i = 7; i >= 5; i--) bit_x(1'b0, r[i]);
        hold_n = 1'b0;
        wait_h();
        chk(!so_oe, "R12", "so_oe during pause", int'(so_oe), 0);
        for (int j = 0; j < 2; j++) begin
            si = ~si;
            sck = 1'b1;
            wait_h();
            sck = 1'b0;
            wait_h();
        end
        chk(!so_oe, "R12", "so_oe after clocks in pause", int'(so_oe), 0);
        hold_n = 1'b1;
        wait_h();
        for (int i = 4; i >= 0; i--) bit_x(1'b0, r[i]);
        chk(r == mem_val(17), "R12", "read byte across pause", r, mem_val(17));
        cs_end("R12");

        // R13: abort inside a data byte, then inside a command byte
        cs_begin(1'b0, "R13");
        push(EV_PLD, 2, 8'h5A, "R13");
        push(EV_CMT, 0, 0, "R13");
        byte_x(8'h02, r);
        byte_x(8'h00, r);
        byte_x(8'h02, r);
        byte_x(8'h5A, r);
        for (int i = 0; i < 3; i++) bit_x(1'b1, rb);
        cs_end("R13");
        cs_begin(1'b0, "R13");
        for (int i = 0; i < 4; i++) bit_x(1'b1, rb);
        cs_end("R13");
        cs_begin(1'b0, "R13");
        push(EV_WSET, 0, 0, "R13");
        byte_x(8'h06, r);
        cs_end("R13");

        done = 1'b1;
        finish_run();
    end
endmodule